// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Target Engine

This block is the protocol side of a small two-wire serial memory target. It watches the SCL and SDA lines, which arrive already filtered and synchronous to the system clock. It controls an open-drain SDA pull-down enable and sequences the bits and bytes of each transfer. It recognises the addressing byte that follows a Start and answers only when the upper four bits carry the fixed device code. It then serves one of four access kinds: byte or multi-byte writes, current-address reads, random reads and sequential reads. The array holds 128 bytes.

Write data does not go straight into the array. Each accepted data byte is handed to a separate page-buffer block together with its target address, and a commit strobe is raised when a Stop ends the write. Read data comes from a simple synchronous memory port that returns data one clock after the request. One 7-bit pointer is shared by all access kinds. Two inputs from the surrounding logic set the access rules: a busy flag, raised while the array is being programmed, makes the target stay silent, and a protect flag keeps writes from reaching the page buffer.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A byte received right after a Start whose bits [7:4] equal 4'b1010 is acknowledged: SDA is pulled low for the ninth clock. Bits [3:1] have no effect, and bit 0 selects a read (1) or a write (0).
- R2: An addressing byte whose bits [7:4] differ from 4'b1010 gets no acknowledge. No byte after it is acknowledged until the next Start.
- R3: The SDA enable is asserted only while SCL is low. It is released only while SCL is low or on a Start or Stop, so the data the target sends stays stable through each SCL high period.
- R4: In a write, the byte after the addressing byte loads the pointer from its bits [6:0]; bit 7 is ignored. Each later byte is acknowledged and passed to the page buffer with the current pointer as its address, and the pointer then advances by one.
- R5: A repeated Start after the word address, followed by a read addressing byte, returns the byte at the loaded address. No data is written.
- R6: A current-address read returns the byte one above the last address accessed, whether that access was a read or a write.
- R7: When the master acknowledges a read byte, the next byte follows at once. The pointer wraps from 0x7F to 0x00.
- R8: When the master does not acknowledge a read byte, the target releases SDA and drives nothing more until the next Start or Stop.
- R9: While protect is high, data bytes are still acknowledged, but no page-buffer write and no commit is issued. Reads are not affected.
- R10: While busy is high, the target gives no acknowledge of any kind and issues no page-buffer write.
- R11: A Start seen at any bit position abandons the byte in progress and restarts reception of an addressing byte.
- R12: A Stop that ends a write with at least one accepted data byte raises the commit strobe for one clock. A write ended by a repeated Start does not commit.
- R13: After reset, SDA is released and every strobe output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Filtered, synchronous SCL level |
| sda_i | input | 1 | Filtered, synchronous SDA level |
| sda_oe_o | output | 1 | SDA pull-down enable (1 drives the line low) |
| wp_i | input | 1 | Write protect: blocks page-buffer writes and commits |
| wr_busy_i | input | 1 | Array programming in progress: no acknowledges |
| mem_rd_o | output | 1 | Read request to the memory port |
| mem_raddr_o | output | 7 | Read address (the current pointer) |
| mem_rdata_i | input | 8 | Read data, valid one clock after the request |
| pb_wr_o | output | 1 | One-clock strobe: a data byte for the page buffer |
| pb_addr_o | output | 7 | Array address of the data byte |
| pb_data_o | output | 8 | Data byte |
| pb_commit_o | output | 1 | One-clock strobe: a Stop ended a write that had data |

## Verification
The assertions check on every cycle that the SDA enable rises only while SCL is low and falls only while SCL is low or on a bus condition. They also check that a page-buffer write never follows a cycle with protect or busy high, and that a commit only ever follows a Stop. Only the bench scenarios can show the byte-level behaviour: which addressing bytes get answered, the data returned by current, random and sequential reads (including the wrap at 0x7F), the order of the page-buffer writes, and the recovery after an aborted byte or a master NACK.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_CTRL,
    ST_RX_ADDR,
    ST_RX_DATA,
    ST_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_HOLD
  } eep_state_e;
endpackage

// File: rtl/eep_bus_cond.sv
`timescale 1ns/1ps
// Edge and bus-condition detection on the synchronous line levels.
module eep_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_lvl_o  = scl_q;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA moving while SCL stays high marks a bus condition
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/eep_ptr.sv
`timescale 1ns/1ps
// Shared word pointer: load from the address byte, step after each byte access.
module eep_ptr #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk) begin
    if (rst)         ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + 1'b1;   // natural wrap at the top
  end
endmodule

// File: rtl/i2c_eeprom_target.sv
`timescale 1ns/1ps
module i2c_eeprom_target #(
  parameter int          AW        = 7,
  parameter int          DW        = 8,
  parameter int          CODE_W    = 4,
  parameter logic [3:0]  CTRL_CODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          wp_i,
  input  logic          wr_busy_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_raddr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          pb_wr_o,
  output logic [AW-1:0] pb_addr_o,
  output logic [DW-1:0] pb_data_o,
  output logic          pb_commit_o
);
  import eep_pkg::*;

  localparam int BCW = $clog2(DW + 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);
  localparam logic [BCW-1:0] ALL_BITS = BCW'(DW);

  logic scl_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  eep_state_e state, after_st;
  logic [BCW-1:0] bitcnt;
  logic [DW-1:0]  shreg, txreg, rx_byte;
  logic           sda_oe, rd_pend, wr_pend;
  logic           ptr_ld, ptr_inc;
  logic [AW-1:0]  ptr_val, ptr;
  logic           byte_end;

  eep_bus_cond u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl_o(scl_lvl), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  eep_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .load_i(ptr_ld), .load_val_i(ptr_val),
    .inc_i(ptr_inc), .ptr_o(ptr)
  );

  assign rx_byte     = {shreg[DW-2:0], sda_i};
  assign byte_end    = scl_rise && (bitcnt == LAST_BIT);
  assign sda_oe_o    = sda_oe;
  assign mem_raddr_o = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      after_st    <= ST_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      txreg       <= '0;
      sda_oe      <= 1'b0;
      rd_pend     <= 1'b0;
      wr_pend     <= 1'b0;
      ptr_ld      <= 1'b0;
      ptr_inc     <= 1'b0;
      ptr_val     <= '0;
      mem_rd_o    <= 1'b0;
      pb_wr_o     <= 1'b0;
      pb_addr_o   <= '0;
      pb_data_o   <= '0;
      pb_commit_o <= 1'b0;
    end else begin
      mem_rd_o    <= 1'b0;
      pb_wr_o     <= 1'b0;
      pb_commit_o <= 1'b0;
      ptr_ld      <= 1'b0;
      ptr_inc     <= 1'b0;
      rd_pend     <= mem_rd_o;

      if (stop_evt) begin
        state       <= ST_IDLE;
        sda_oe      <= 1'b0;
        pb_commit_o <= wr_pend;
        wr_pend     <= 1'b0;
      end else if (start_evt) begin
        state   <= ST_RX_CTRL;
        bitcnt  <= '0;
        sda_oe  <= 1'b0;
        wr_pend <= 1'b0;          // a repeated Start drops the write
      end else begin
        case (state)
          ST_RX_CTRL, ST_RX_ADDR, ST_RX_DATA: begin
            if (scl_rise) begin
              shreg  <= rx_byte;
              bitcnt <= bitcnt + 1'b1;
            end
            if (byte_end) begin
              bitcnt <= '0;
              if (wr_busy_i) begin
                state <= ST_HOLD;   // silent while programming
              end else if (state == ST_RX_CTRL) begin
                if (rx_byte[DW-1 -: CODE_W] == CTRL_CODE) begin
                  state <= ST_ACK;
                  if (rx_byte[0]) begin
                    after_st <= ST_TX;
                    mem_rd_o <= 1'b1;
                  end else begin
                    after_st <= ST_RX_ADDR;
                  end
                end else begin
                  state <= ST_HOLD;
                end
              end else if (state == ST_RX_ADDR) begin
                ptr_ld   <= 1'b1;
                ptr_val  <= rx_byte[AW-1:0];
                state    <= ST_ACK;
                after_st <= ST_RX_DATA;
              end else begin
                if (!wp_i) begin
                  pb_wr_o   <= 1'b1;
                  pb_addr_o <= ptr;
                  pb_data_o <= rx_byte;
                  wr_pend   <= 1'b1;
                end
                ptr_inc  <= 1'b1;
                state    <= ST_ACK;
                after_st <= ST_RX_DATA;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (!sda_oe) begin
                sda_oe <= 1'b1;     // ninth clock: pull low
              end else begin
                bitcnt <= '0;
                state  <= after_st;
                sda_oe <= (after_st == ST_TX) ? ~txreg[DW-1] : 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
              txreg  <= {txreg[DW-2:0], 1'b0};
              if (bitcnt == LAST_BIT) ptr_inc <= 1'b1;
            end
            if (scl_fall) begin
              if (bitcnt == ALL_BITS) begin
                sda_oe <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                sda_oe <= ~txreg[DW-1];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              if (!sda_i) begin
                mem_rd_o <= 1'b1;
                bitcnt   <= '0;
                state    <= ST_TX;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end

      if (rd_pend) txreg <= mem_rdata_i;
    end
  end

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_lvl);  // R3
  AST_OE_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe_o) |-> (!scl_lvl || $past(start_evt || stop_evt)));  // R3
  AST_WP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    pb_wr_o |-> !$past(wp_i));  // R9
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    pb_wr_o |-> !$past(wr_busy_i));  // R10
  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    pb_commit_o |-> $past(stop_evt));  // R12
endmodule

// File: tb/i2c_eeprom_target_test.sv
`timescale 1ns/1ps
module i2c_eeprom_target_test;
  localparam int Q = 8;   // system clocks per quarter SCL period

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic wp = 1'b0, busy = 1'b0;
  logic sda_oe, mem_rd, pb_wr, pb_commit;
  logic [6:0] mem_raddr, pb_addr;
  logic [7:0] mem_rdata, pb_data;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  i2c_eeprom_target uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .wp_i(wp), .wr_busy_i(busy),
    .mem_rd_o(mem_rd), .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata),
    .pb_wr_o(pb_wr), .pb_addr_o(pb_addr), .pb_data_o(pb_data),
    .pb_commit_o(pb_commit)
  );

  logic [7:0] bmem [0:127];
  initial for (int i = 0; i < 128; i++) bmem[i] = 8'((i * 37 + 11) & 8'hFF);
  initial mem_rdata = 8'h00;
  always @(posedge clk) if (mem_rd) mem_rdata <= bmem[mem_raddr];

  int n_checks = 0, n_fail = 0, commit_cnt = 0;
  bit done = 1'b0;
  logic [14:0] exp_wr[$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor for page-buffer traffic
  always @(negedge clk) begin
    if (!rst && pb_wr) begin
      if (exp_wr.size() == 0) begin
        chk(1'b0, "R9/R10 unexpected page write", {pb_addr, pb_data}, 0);
      end else begin
        logic [14:0] e;
        e = exp_wr.pop_front();
        chk({pb_addr, pb_data} == e, "R4 page write addr/data", {pb_addr, pb_data}, e);
      end
    end
    if (!rst && pb_commit) commit_cnt++;
  end

  task automatic qwait(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; qwait(); scl_m = 1'b1; qwait();
    s = sda_line; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] d);
    logic s0, s1;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait(); scl_m = 1'b1; repeat (2) @(negedge clk);
      s0 = sda_line; repeat (Q - 2) @(negedge clk);
      d[i] = s0; repeat (Q - 2) @(negedge clk);
      s1 = sda_line;
      chk(s0 == s1, "R3 data stable while SCL high", s1, s0);
      repeat (2) @(negedge clk); scl_m = 1'b0; qwait();
    end
    sda_m = !mack; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
  endtask

  bit ack;
  logic [7:0] d;
  int c0;

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sda_oe == 1'b0 && pb_wr == 1'b0 && pb_commit == 1'b0 && mem_rd == 1'b0,
        "R13 reset outputs", {sda_oe, pb_wr, pb_commit, mem_rd}, 0);

    // R1: match with block bits set, write direction
    bus_start(); send_byte(8'hAE, ack);
    chk(ack, "R1 addressing byte 0xAE", ack, 1);
    bus_stop();

    // R2: non-matching code, then silence for the rest of the transfer
    bus_start(); send_byte(8'h90, ack);
    chk(!ack, "R2 wrong code not acked", ack, 0);
    send_byte(8'hA0, ack);
    chk(!ack, "R2 silent until Start", ack, 0);
    bus_stop();

    // R4/R12: byte write
    c0 = commit_cnt;
    exp_wr.push_back({7'h15, 8'h3C});
    bus_start(); send_byte(8'hA0, ack); chk(ack, "R1 write addressing", ack, 1);
    send_byte(8'h15, ack); chk(ack, "R4 word address acked", ack, 1);
    send_byte(8'h3C, ack); chk(ack, "R4 data acked", ack, 1);
    bus_stop(); qwait();
    chk(commit_cnt == c0 + 1, "R12 commit after Stop", commit_cnt, c0 + 1);

    // R4: multi-byte write with address MSB set (0xC2 -> 0x42)
    c0 = commit_cnt;
    bus_start(); send_byte(8'hA0, ack); send_byte(8'hC2, ack);
    for (int i = 0; i < 3; i++) begin
      exp_wr.push_back({7'(7'h42 + i), 8'(8'h70 + i)});
      send_byte(8'(8'h70 + i), ack);
      chk(ack, "R4 page data acked", ack, 1);
    end
    bus_stop(); qwait();
    chk(commit_cnt == c0 + 1, "R12 single commit for page", commit_cnt, c0 + 1);
    chk(exp_wr.size() == 0, "R4 all page writes seen", exp_wr.size(), 0);

    // R6: pointer advanced past the write (last 0x44 -> read 0x45)
    bus_start(); send_byte(8'hA1, ack); chk(ack, "R1 read addressing", ack, 1);
    read_byte(1'b0, d); bus_stop();
    chk(d == bmem[7'h45], "R6 current read after write", d, bmem[7'h45]);

    // R5: random read
    c0 = commit_cnt;
    bus_start(); send_byte(8'hA0, ack); send_byte(8'h20, ack);
    bus_start(); send_byte(8'hA1, ack); chk(ack, "R5 read after repeated Start", ack, 1);
    read_byte(1'b0, d); bus_stop(); qwait();
    chk(d == bmem[7'h20], "R5 random read data", d, bmem[7'h20]);
    chk(commit_cnt == c0, "R5 no commit without data", commit_cnt, c0);

    // R6: current read follows a read
    bus_start(); send_byte(8'hA1, ack); read_byte(1'b0, d); bus_stop();
    chk(d == bmem[7'h21], "R6 current read after read", d, bmem[7'h21]);

    // R7: sequential read through the wrap
    bus_start(); send_byte(8'hA0, ack); send_byte(8'h7E, ack);
    bus_start(); send_byte(8'hA1, ack);
    read_byte(1'b1, d); chk(d == bmem[7'h7E], "R7 seq byte 0x7E", d, bmem[7'h7E]);
    read_byte(1'b1, d); chk(d == bmem[7'h7F], "R7 seq byte 0x7F", d, bmem[7'h7F]);
    read_byte(1'b0, d); chk(d == bmem[7'h00], "R7 wrap to 0x00", d, bmem[7'h00]);
    // R8: after the NACK the target drives nothing
    repeat (3 * Q) @(negedge clk);
    chk(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
    send_byte(8'h00, ack);
    chk(!ack && sda_oe == 1'b0, "R8 no drive before Stop", ack, 0);
    bus_stop();
    bus_start(); send_byte(8'hA1, ack); read_byte(1'b0, d); bus_stop();
    chk(d == bmem[7'h01], "R6 pointer after wrap", d, bmem[7'h01]);

    // R12: repeated Start after data does not commit
    c0 = commit_cnt;
    exp_wr.push_back({7'h30, 8'h11});
    bus_start(); send_byte(8'hA0, ack); send_byte(8'h30, ack); send_byte(8'h11, ack);
    bus_start(); send_byte(8'hA1, ack); read_byte(1'b0, d); bus_stop(); qwait();
    chk(d == bmem[7'h31], "R6 read after data byte", d, bmem[7'h31]);
    chk(commit_cnt == c0, "R12 no commit on repeated Start", commit_cnt, c0);

    // R9: write protect
    wp = 1'b1; c0 = commit_cnt;
    bus_start(); send_byte(8'hA0, ack); send_byte(8'h10, ack);
    send_byte(8'h77, ack); chk(ack, "R9 protected data still acked", ack, 1);
    bus_stop(); qwait();
    chk(commit_cnt == c0, "R9 no commit under protect", commit_cnt, c0);
    bus_start(); send_byte(8'hA1, ack); read_byte(1'b0, d); bus_stop();
    chk(d == bmem[7'h11], "R9 read unaffected", d, bmem[7'h11]);
    wp = 1'b0;

    // R10: busy
    busy = 1'b1;
    bus_start(); send_byte(8'hA0, ack); chk(!ack, "R10 busy write not acked", ack, 0);
    bus_stop();
    bus_start(); send_byte(8'hA1, ack); chk(!ack, "R10 busy read not acked", ack, 0);
    bus_stop();
    busy = 1'b0;

    // R11: Start inside a byte
    begin
      logic s;
      bus_start(); clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b1, s);
    end
    bus_start(); send_byte(8'hA0, ack); chk(ack, "R11 restart after abort", ack, 1);
    send_byte(8'h55, ack);
    bus_start(); send_byte(8'hA1, ack); read_byte(1'b0, d); bus_stop();
    chk(d == bmem[7'h55], "R11 address after abort", d, bmem[7'h55]);

    chk(exp_wr.size() == 0, "R4 scoreboard drained", exp_wr.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL R13 watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule